// File: doc/BRIEF.md
# Register Rename Map with Physical Tag Pool

This block renames one instruction per cycle for an out-of-order core. Architectural register names are translated to tags from a larger physical register pool. A map table holds the current physical tag for each architectural register. A circular FIFO holds the physical tags that nobody owns. Each instruction gives up to two source names and an optional destination name. The block returns the physical tags of both sources and a newly allocated tag for the destination, all in the same cycle that it accepts the instruction. Because of this, a later reader of a register sees the tag of its latest writer, so read-after-write order is kept. Two writers of the same name get distinct tags, which removes write-after-write conflicts. A writer's tag also differs from the tag that earlier readers still hold, which removes write-after-read conflicts.

Both sources are read before the destination is remapped. A source that names the register the same instruction writes therefore gets the older tag. A source flagged as an immediate bypasses the map and comes out as its raw field, zero-extended. Architectural register 0 is hardwired: it always reads tag 0, and it is never remapped. A tag is handed back to the pool through a release strobe, and that strobe may fire in the same cycle as an allocation.

A small state machine sequences the block:
- `ST_FILL` pushes the spare tags into the FIFO, one per cycle, after reset.
- `ST_RUN` is normal operation with tags available.
- `ST_DRY` means the pool is empty.

The block has these transitions:
- FILL→RUN when the last spare tag has been pushed.
- RUN→DRY when the FIFO count becomes zero after a cycle's pushes and pops.
- DRY→RUN when a release refills the pool.

Top module: `rename_unit`

## Requirements
- R1: After the fill, architectural register rN reads back as physical tag N for every N.
- R2: After reset, `in_ready` stays low for exactly NUM_PHYS−NUM_ARCH cycles. The first destinations then receive tags NUM_ARCH, NUM_ARCH+1, … in ascending order (8, 9, 10, … by default).
- R3: An accepted instruction with a nonzero destination takes the FIFO head as `out_dst_tag`. From then on, a source naming that register reads this new tag.
- R4: A source that names the instruction's own destination returns the mapping from before this instruction.
- R5: A source with its immediate flag set returns its 3-bit field, zero-extended to the tag width, whatever the map holds.
- R6: Architectural register 0 always reads tag 0. A destination of r0 returns `out_dst_tag` = 0, consumes no tag and changes no mapping.
- R7: When the pool is empty and the instruction has a nonzero destination, `in_ready` and `out_valid` are low, and neither the map nor the pool changes.
- R8: An instruction with no destination, or with destination r0, is accepted even while the pool is empty.
- R9: A released tag goes to the tail of the FIFO and is handed out after all tags already in the pool. A release into an empty pool raises `in_ready` in the next cycle.
- R10: A release and an allocation in the same cycle both take effect. The allocation gets the old head, and the pool count is unchanged.
- R11: `out_valid` equals `in_valid && in_ready`. A cycle with `in_valid` low changes neither the map nor the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented for renaming |
| in_dst_en | input | 1 | Instruction writes a destination |
| in_dst_arch | input | 3 | Architectural destination |
| in_src1_arch | input | 3 | First source name or immediate field |
| in_src1_imm | input | 1 | First source is an immediate |
| in_src2_arch | input | 3 | Second source name or immediate field |
| in_src2_imm | input | 1 | Second source is an immediate |
| rel_valid | input | 1 | Return a tag to the pool |
| rel_tag | input | 4 | Tag being returned |
| in_ready | output | 1 | Block can accept the presented instruction |
| out_valid | output | 1 | Instruction renamed this cycle |
| out_src1_tag | output | 4 | Physical tag of the first source |
| out_src2_tag | output | 4 | Physical tag of the second source |
| out_dst_tag | output | 4 | Newly allocated destination tag |

## Verification
Allocation and release can fall in the same cycle, because both touch the FIFO at once. The bench drains the pool with releases outstanding, then presents an allocating instruction in the same cycle as a release strobe. It judges the result in two ways. The renamed destination must be the old head. The two following allocations must yield the released tag once, and then a stall, which shows the pool count did not move.

// File: rtl/rename_pkg.sv
package rename_pkg;
    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_RUN  = 2'd1,
        ST_DRY  = 2'd2
    } rn_state_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ARCH = 8,
    parameter int TAG_W    = 4,
    parameter int ARCH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARCH_W-1:0] rd1_idx,
    output logic [TAG_W-1:0]  rd1_tag,
    input  logic [ARCH_W-1:0] rd2_idx,
    output logic [TAG_W-1:0]  rd2_tag,
    input  logic              wr_en,
    input  logic [ARCH_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]  wr_tag
);
    logic [TAG_W-1:0] entry [NUM_ARCH];

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
        if (g == 0) begin : g_zero
            // register 0 is wired to physical tag 0
            assign entry[g] = '0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n)
                    entry[g] <= TAG_W'(g);
                else if (wr_en && wr_idx == ARCH_W'(g))
                    entry[g] <= wr_tag;
            end
        end
    end

    assign rd1_tag = entry[rd1_idx];
    assign rd2_tag = entry[rd2_idx];
endmodule

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic [CNT_W-1:0] count
);
    logic [TAG_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    // storage carries no reset value; the controller fills it after reset
    always_ff @(posedge clk) begin
        if (push)
            slot[wr_ptr] <= push_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_tag = slot[rd_ptr];
endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rename_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int ARCH_W   = $clog2(NUM_ARCH),
    localparam int TAG_W    = $clog2(NUM_PHYS),
    localparam int FL_DEPTH = NUM_PHYS - NUM_ARCH,
    localparam int CNT_W    = $clog2(FL_DEPTH + 1),
    localparam int FILL_W   = (FL_DEPTH > 1) ? $clog2(FL_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_dst_en,
    input  logic [ARCH_W-1:0] in_dst_arch,
    input  logic [ARCH_W-1:0] in_src1_arch,
    input  logic              in_src1_imm,
    input  logic [ARCH_W-1:0] in_src2_arch,
    input  logic              in_src2_imm,
    input  logic              rel_valid,
    input  logic [TAG_W-1:0]  rel_tag,
    output logic              in_ready,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_src1_tag,
    output logic [TAG_W-1:0]  out_src2_tag,
    output logic [TAG_W-1:0]  out_dst_tag
);
    rn_state_e         state_q, state_d;
    logic [FILL_W-1:0] fill_q;
    logic              push;
    logic [TAG_W-1:0]  push_tag;
    logic              pop;
    logic              needs_alloc;
    logic [TAG_W-1:0]  head_tag;
    logic [CNT_W-1:0]  fl_count;
    logic [CNT_W:0]    cnt_nxt;
    logic [TAG_W-1:0]  map1_tag, map2_tag;
    logic              filling;

    assign needs_alloc = in_dst_en && (in_dst_arch != '0);
    assign filling     = (state_q == ST_FILL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL)
                fill_q <= fill_q + 1'b1;
        end
    end

    // outputs of each state
    always_comb begin
        in_ready = 1'b0;
        push     = 1'b0;
        push_tag = rel_tag;
        unique case (state_q)
            ST_FILL: begin
                push     = 1'b1;
                push_tag = TAG_W'(NUM_ARCH) + TAG_W'(fill_q);
            end
            ST_RUN: begin
                in_ready = 1'b1;
                push     = rel_valid;
            end
            ST_DRY: begin
                in_ready = !needs_alloc;
                push     = rel_valid;
            end
            default: ;
        endcase
    end

    assign out_valid = in_valid && in_ready;
    assign pop       = out_valid && needs_alloc;
    assign cnt_nxt   = {1'b0, fl_count} + (CNT_W+1)'(push) - (CNT_W+1)'(pop);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (fill_q == FILL_W'(FL_DEPTH - 1)) state_d = ST_RUN;
            ST_RUN:  if (cnt_nxt == '0) state_d = ST_DRY;
            ST_DRY:  if (cnt_nxt != '0) state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    rn_map_table #(
        .NUM_ARCH (NUM_ARCH),
        .TAG_W    (TAG_W),
        .ARCH_W   (ARCH_W)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd1_idx (in_src1_arch),
        .rd1_tag (map1_tag),
        .rd2_idx (in_src2_arch),
        .rd2_tag (map2_tag),
        .wr_en   (pop),
        .wr_idx  (in_dst_arch),
        .wr_tag  (head_tag)
    );

    rn_free_fifo #(
        .DEPTH (FL_DEPTH),
        .TAG_W (TAG_W)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_tag (push_tag),
        .pop      (pop),
        .head_tag (head_tag),
        .count    (fl_count)
    );

    assign out_src1_tag = in_src1_imm ? TAG_W'(in_src1_arch) : map1_tag;
    assign out_src2_tag = in_src2_imm ? TAG_W'(in_src2_arch) : map2_tag;
    assign out_dst_tag  = needs_alloc ? head_tag : '0;
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
    parameter int ARCH_W   = 3,
    parameter int TAG_W    = 4,
    parameter int CNT_W    = 4,
    parameter int FL_DEPTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_dst_en,
    input logic [ARCH_W-1:0] in_dst_arch,
    input logic [ARCH_W-1:0] in_src1_arch,
    input logic              in_src1_imm,
    input logic              in_ready,
    input logic              out_valid,
    input logic [TAG_W-1:0]  out_src1_tag,
    input logic [TAG_W-1:0]  out_dst_tag,
    input logic              rel_valid,
    input logic [CNT_W-1:0]  fl_count,
    input logic              filling
);
    a_r2_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> !in_ready);

    a_r7_empty_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (!filling && fl_count == '0 && in_dst_en && in_dst_arch != '0) |-> !in_ready);

    a_r3_raw_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid && in_dst_en && in_dst_arch != '0) && !in_src1_imm &&
         in_src1_arch == $past(in_dst_arch)) |-> out_src1_tag == $past(out_dst_tag));

    a_r6_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_src1_imm && in_src1_arch == '0) |-> out_src1_tag == '0);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !filling) |-> fl_count < CNT_W'(FL_DEPTH));

    a_r10_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_dst_en && in_dst_arch != '0 && rel_valid && !filling)
        |=> fl_count == $past(fl_count));
endmodule

bind rename_unit rename_unit_chk #(
    .ARCH_W   (ARCH_W),
    .TAG_W    (TAG_W),
    .CNT_W    (CNT_W),
    .FL_DEPTH (FL_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_dst_en    (in_dst_en),
    .in_dst_arch  (in_dst_arch),
    .in_src1_arch (in_src1_arch),
    .in_src1_imm  (in_src1_imm),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_src1_tag (out_src1_tag),
    .out_dst_tag  (out_dst_tag),
    .rel_valid    (rel_valid),
    .fl_count     (fl_count),
    .filling      (filling)
);

// File: tb/rename_unit_tb.sv
`timescale 1ns/1ps
module rename_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_dst_en = 1'b0;
    logic [2:0] in_dst_arch = '0;
    logic [2:0] in_src1_arch = '0;
    logic       in_src1_imm = 1'b0;
    logic [2:0] in_src2_arch = '0;
    logic       in_src2_imm = 1'b0;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_tag = '0;
    logic       in_ready, out_valid;
    logic [3:0] out_src1_tag, out_src2_tag, out_dst_tag;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rename_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_en(in_dst_en),
        .in_dst_arch(in_dst_arch), .in_src1_arch(in_src1_arch), .in_src1_imm(in_src1_imm),
        .in_src2_arch(in_src2_arch), .in_src2_imm(in_src2_imm), .rel_valid(rel_valid),
        .rel_tag(rel_tag), .in_ready(in_ready), .out_valid(out_valid),
        .out_src1_tag(out_src1_tag), .out_src2_tag(out_src2_tag), .out_dst_tag(out_dst_tag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at the falling edge, let it settle, leave sampling to the caller
    task automatic drive(input bit v, input bit den, input int d, input int s1, input bit i1,
                         input int s2, input bit i2, input bit rv, input int rt);
        in_valid = v; in_dst_en = den; in_dst_arch = 3'(d);
        in_src1_arch = 3'(s1); in_src1_imm = i1;
        in_src2_arch = 3'(s2); in_src2_imm = i2;
        rel_valid = rv; rel_tag = 4'(rt);
        #1;
    endtask

    task automatic next_cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_fill();
        int low = 0;
        chk("R2 ready in reset", int'(in_ready), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (in_ready) break;
            low++;
            next_cyc();
        end
        chk("R2 fill length", low, 8);
    endtask

    task automatic t_reset_map();
        for (int n = 0; n < 8; n++) begin
            drive(1, 0, 0, n, 0, 7 - n, 0, 0, 0);
            chk("R1 src1 identity", int'(out_src1_tag), n);
            chk("R1 src2 identity", int'(out_src2_tag), 7 - n);
            next_cyc();
        end
    endtask

    task automatic t_alloc_order();
        drive(1, 1, 1, 1, 0, 4, 1, 0, 0);     // r1 = r1 / #4
        chk("R4 own source old tag", int'(out_src1_tag), 1);
        chk("R5 immediate passthrough", int'(out_src2_tag), 4);
        chk("R2 first tag", int'(out_dst_tag), 8);
        chk("R11 out_valid", int'(out_valid), 1);
        next_cyc();
        drive(1, 1, 2, 1, 0, 3, 0, 0, 0);
        chk("R3 raw follows writer", int'(out_src1_tag), 8);
        chk("R2 second tag", int'(out_dst_tag), 9);
        next_cyc();
        drive(1, 1, 3, 3, 0, 2, 0, 0, 0);
        chk("R4 own source old tag r3", int'(out_src1_tag), 3);
        chk("R3 raw r2", int'(out_src2_tag), 9);
        chk("R2 third tag", int'(out_dst_tag), 10);
        next_cyc();
    endtask

    task automatic t_zero_dst();
        drive(1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 r0 dst tag", int'(out_dst_tag), 0);
        chk("R6 r0 src", int'(out_src1_tag), 0);
        next_cyc();
        drive(1, 1, 4, 0, 0, 4, 0, 0, 0);
        chk("R6 r0 consumed nothing", int'(out_dst_tag), 11);
        chk("R6 r0 still zero", int'(out_src1_tag), 0);
        next_cyc();
    endtask

    task automatic t_idle();
        drive(0, 1, 5, 0, 0, 0, 0, 0, 0);
        chk("R11 no valid when idle", int'(out_valid), 0);
        next_cyc();
        drive(1, 1, 5, 5, 0, 0, 0, 0, 0);
        chk("R11 idle took no tag", int'(out_dst_tag), 12);
        chk("R11 idle kept map", int'(out_src1_tag), 5);
        next_cyc();
    endtask

    task automatic t_drain_stall();
        drive(1, 1, 6, 0, 0, 0, 0, 0, 0);
        chk("R3 alloc r6", int'(out_dst_tag), 13);
        next_cyc();
        drive(1, 1, 7, 0, 0, 0, 0, 0, 0);
        chk("R3 alloc r7", int'(out_dst_tag), 14);
        next_cyc();
        drive(1, 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R3 last tag", int'(out_dst_tag), 15);
        next_cyc();
        for (int k = 0; k < 2; k++) begin
            drive(1, 1, 2, 2, 0, 0, 0, 0, 0);
            chk("R7 stall ready", int'(in_ready), 0);
            chk("R7 stall valid", int'(out_valid), 0);
            next_cyc();
        end
        drive(1, 0, 0, 2, 0, 4, 1, 0, 0);
        chk("R8 no-dst accepted", int'(out_valid), 1);
        chk("R7 map kept r2", int'(out_src1_tag), 9);
        chk("R5 imm over mapped r4", int'(out_src2_tag), 4);
        next_cyc();
        drive(1, 1, 0, 1, 0, 0, 0, 0, 0);
        chk("R8 r0 dst accepted", int'(out_valid), 1);
        chk("R3 r1 now p15", int'(out_src1_tag), 15);
        next_cyc();
    endtask

    task automatic t_release();
        drive(0, 0, 0, 0, 0, 0, 0, 1, 8);
        next_cyc();
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1);
        next_cyc();
        drive(1, 1, 2, 2, 0, 0, 0, 0, 0);
        chk("R9 ready after release", int'(in_ready), 1);
        chk("R9 first released first", int'(out_dst_tag), 8);
        chk("R4 own source r2", int'(out_src1_tag), 9);
        next_cyc();
        drive(1, 1, 3, 0, 0, 0, 0, 1, 9);   // allocate and release together
        chk("R10 alloc with release", int'(out_dst_tag), 1);
        next_cyc();
        drive(1, 1, 4, 0, 0, 0, 0, 0, 0);
        chk("R10 released tag appended", int'(out_dst_tag), 9);
        next_cyc();
        drive(1, 1, 5, 0, 0, 0, 0, 0, 0);
        chk("R10 count balanced", int'(in_ready), 0);
        next_cyc();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_fill();
        t_reset_map();
        t_alloc_order();
        t_zero_dst();
        t_idle();
        t_drain_stall();
        t_release();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #20000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule